// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable slave that answers a three-wire serial EEPROM protocol with a select line, a serial clock, a data input and a data output. It contains a store of 64 words of 16 bits and a write-enable latch. A host raises the select line, clocks in a start bit, a two-bit opcode and a six-bit address, and clocks in sixteen data bits where the command needs them. The slave then returns the addressed word, or it changes one word or every word.

The block runs on a fast system clock. It passes the select, serial clock and data input through a short synchronizer, and each rising edge of the serial clock counts as one bit time. Every programming command takes effect as soon as its last bit arrives, so there is no busy period. The store resets to the erased value, all ones, and the write-enable latch resets to cleared. The block stands in for a real part in system-level simulation and in FPGA prototypes of a host that boots from such a device.

Top module: `mw_eeprom_model`

## Requirements
- R1: The slave samples input bits on rising serial clock edges while select is high. Zeros before the first 1 are skipped, and that first 1 is taken as the start bit. Serial clock edges while select is low have no effect.
- R2: Opcode 2'b10 is a read. After the last address bit, the output shows a 0 for one bit time. The sixteen bits of the addressed word follow, most significant first, and each new bit appears after a rising serial clock edge.
- R3: Opcode 2'b01 is a write. The six address bits, most significant first, are followed by sixteen data bits, most significant first, and the addressed word takes that data.
- R4: Opcode 2'b11 is an erase. It sets the addressed word to 16'hFFFF and leaves the other words unchanged.
- R5: With opcode 2'b00, address bits [5:4] select the command: 2'b11 sets the write-enable latch and 2'b00 clears it. Address bits [3:0] are ignored.
- R6: With opcode 2'b00 and address bits [5:4] = 2'b10, every word is set to 16'hFFFF.
- R7: With opcode 2'b00 and address bits [5:4] = 2'b01, sixteen data bits follow the address, and every word takes that data.
- R8: The write-enable latch is cleared at reset. Write, erase, erase-all and write-all leave the store unchanged while the latch is clear.
- R9: The data output is low whenever select is low and whenever no read data is being shifted out.
- R10: After reset every word reads 16'hFFFF.
- R11: Dropping select before a command is complete aborts the command, leaves the store unchanged and returns the slave to waiting for a start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Select; a command is framed while it is high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial command, address and data input |
| dout | output | 1 | Serial read data output |

## Verification
Every one of the 64 addresses is swept with a write and a read of an address-derived pattern. A wrong shift order or a wrong address decode would return data from another word or with its bits reordered. Each read checks that the leading 0 comes before the data, so a design that omits this bit or drives the word one bit time early shows a shifted value. Programming commands are sent with the latch cleared, and also with select held low, and the store must stay the same; a design without the enable gate, or one that listens while deselected, would corrupt the sweep. A write cut off by dropping select part way through the data must leave the word unchanged. Erase-all and write-all are each followed by a full sweep of the store, which finds a broadcast that misses some words.

// File: rtl/mw_pkg.sv
package mw_pkg;

   localparam logic [1:0] OP_EXT   = 2'b00;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_ERASE = 2'b11;

   localparam logic [1:0] EX_LOCK  = 2'b00;
   localparam logic [1:0] EX_FILL  = 2'b01;
   localparam logic [1:0] EX_WIPE  = 2'b10;
   localparam logic [1:0] EX_OPEN  = 2'b11;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADR,
      ST_DAT,
      ST_RD,
      ST_DONE
   } mw_state_e;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_WRITE,
      CMD_ERASE,
      CMD_WIPE,
      CMD_FILL,
      CMD_OPEN,
      CMD_LOCK
   } mw_cmd_e;

endpackage

// File: rtl/mw_sync_edge.sv
module mw_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sk,
   input  logic di,
   output logic cs_s,
   output logic di_s,
   output logic sk_rise
);

   logic [2:0] tail;
   logic       sk_prev;

   generate
      if (STAGES == 1) begin : g_single
         logic [2:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= {cs, sk, di};
         end
         assign tail = r;
      end else begin : g_chain
         logic [STAGES-1:0][2:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= {r[STAGES-2:0], {cs, sk, di}};
         end
         assign tail = r[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sk_prev <= 1'b0;
      else        sk_prev <= tail[1];
   end

   assign cs_s    = tail[2];
   assign di_s    = tail[0];
   assign sk_rise = tail[1] & ~sk_prev;

endmodule

// File: rtl/mw_store.sv
module mw_store
   import mw_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_vld,
   input  mw_cmd_e           cmd,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              wen
);

   localparam int WORDS = 1 << ADDR_W;

   logic [WORDS-1:0][DATA_W-1:0] words;
   logic                         prog_ok;

   assign prog_ok = cmd_vld & wen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen <= 1'b0;
      end else if (cmd_vld) begin
         if (cmd == CMD_OPEN)      wen <= 1'b1;
         else if (cmd == CMD_LOCK) wen <= 1'b0;
      end
   end

   generate
      for (genvar g = 0; g < WORDS; g++) begin : g_word
         logic [DATA_W-1:0] q;
         logic              hit;
         assign hit = (cmd_addr == ADDR_W'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '1;
            end else if (prog_ok) begin
               if ((cmd == CMD_WRITE && hit) || cmd == CMD_FILL)
                  q <= cmd_data;
               else if ((cmd == CMD_ERASE && hit) || cmd == CMD_WIPE)
                  q <= '1;
            end
         end
         assign words[g] = q;
      end
   endgenerate

   assign rd_data = words[rd_addr];

endmodule

// File: rtl/mw_fsm.sv
module mw_fsm
   import mw_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sk_rise,
   input  logic              di_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              cmd_vld,
   output mw_cmd_e           cmd,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data,
   output logic              dout,
   output logic              idle,
   output logic              rd_start
);

   localparam int CW = $clog2(DATA_W + 1);

   mw_state_e         state;
   logic [CW-1:0]     cnt;
   logic [1:0]        op;
   logic [ADDR_W-1:0] adr;
   logic [DATA_W-1:0] dat;
   logic [DATA_W:0]   sh;
   logic [ADDR_W-1:0] nxt_adr;
   logic [DATA_W-1:0] nxt_dat;
   logic [1:0]        ext;

   assign nxt_adr = {adr[ADDR_W-2:0], di_s};
   assign nxt_dat = {dat[DATA_W-2:0], di_s};
   assign ext     = nxt_adr[ADDR_W-1 -: 2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         op       <= '0;
         adr      <= '0;
         dat      <= '0;
         sh       <= '0;
         cmd_vld  <= 1'b0;
         cmd      <= CMD_NONE;
         cmd_addr <= '0;
         cmd_data <= '0;
         rd_start <= 1'b0;
      end else begin
         cmd_vld  <= 1'b0;
         rd_start <= 1'b0;
         if (rd_start) sh <= {1'b0, rd_data};
         if (!cs_s) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sh    <= '0;
         end else if (sk_rise) begin
            case (state)
               ST_IDLE: begin
                  if (di_s) begin
                     state <= ST_OPC;
                     cnt   <= '0;
                  end
               end
               ST_OPC: begin
                  op <= {op[0], di_s};
                  if (cnt == CW'(1)) begin
                     state <= ST_ADR;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_ADR: begin
                  adr <= nxt_adr;
                  if (cnt == CW'(ADDR_W - 1)) begin
                     cnt      <= '0;
                     cmd_addr <= nxt_adr;
                     case (op)
                        OP_READ: begin
                           state    <= ST_RD;
                           sh       <= '0;
                           rd_start <= 1'b1;
                        end
                        OP_WRITE: state <= ST_DAT;
                        OP_ERASE: begin
                           state   <= ST_DONE;
                           cmd_vld <= 1'b1;
                           cmd     <= CMD_ERASE;
                        end
                        default: begin
                           if (ext == EX_FILL) begin
                              state <= ST_DAT;
                           end else begin
                              state   <= ST_DONE;
                              cmd_vld <= 1'b1;
                              cmd     <= (ext == EX_OPEN) ? CMD_OPEN :
                                         (ext == EX_WIPE) ? CMD_WIPE : CMD_LOCK;
                           end
                        end
                     endcase
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DAT: begin
                  dat <= nxt_dat;
                  if (cnt == CW'(DATA_W - 1)) begin
                     state    <= ST_DONE;
                     cnt      <= '0;
                     cmd_vld  <= 1'b1;
                     cmd_data <= nxt_dat;
                     cmd      <= (op == OP_WRITE) ? CMD_WRITE : CMD_FILL;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_RD: begin
                  if (cnt == CW'(DATA_W)) begin
                     state <= ST_DONE;
                     cnt   <= '0;
                     sh    <= '0;
                  end else begin
                     sh  <= {sh[DATA_W-1:0], 1'b0};
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= ST_DONE;
            endcase
         end
      end
   end

   assign rd_addr = adr;
   assign dout    = (state == ST_RD) & sh[DATA_W];
   assign idle    = (state == ST_IDLE);

endmodule

// File: rtl/mw_eeprom_model.sv
module mw_eeprom_model
   import mw_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sk,
   input  logic di,
   output logic dout
);

   generate
      if (ADDR_W < 2 || ADDR_W > DATA_W) begin : g_bad_addr
         $error("mw_eeprom_model: ADDR_W must be in 2..DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("mw_eeprom_model: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("mw_eeprom_model: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic              cs_s;
   logic              di_s;
   logic              sk_rise;
   logic [ADDR_W-1:0] rd_addr;
   logic [DATA_W-1:0] rd_data;
   logic              cmd_vld;
   mw_cmd_e           cmd;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] cmd_data;
   logic              wen;
   logic              idle;
   logic              rd_start;

   mw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs      (cs),
      .sk      (sk),
      .di      (di),
      .cs_s    (cs_s),
      .di_s    (di_s),
      .sk_rise (sk_rise)
   );

   mw_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_s     (cs_s),
      .sk_rise  (sk_rise),
      .di_s     (di_s),
      .rd_data  (rd_data),
      .rd_addr  (rd_addr),
      .cmd_vld  (cmd_vld),
      .cmd      (cmd),
      .cmd_addr (cmd_addr),
      .cmd_data (cmd_data),
      .dout     (dout),
      .idle     (idle),
      .rd_start (rd_start)
   );

   mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_vld  (cmd_vld),
      .cmd      (cmd),
      .cmd_addr (cmd_addr),
      .cmd_data (cmd_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .wen      (wen)
   );

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
   import mw_pkg::*;
(
   input logic    clk,
   input logic    rst_n,
   input logic    cs_s,
   input logic    sk_rise,
   input logic    di_s,
   input logic    dout,
   input logic    idle,
   input logic    rd_start,
   input logic    cmd_vld,
   input mw_cmd_e cmd,
   input logic    wen
);

   // R1: the idle state is left only on a start bit seen while selected
   p_start_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !(cs_s && sk_rise && di_s)) |=> idle);

   // R2: the bit time after the address shows the leading zero
   p_lead_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |=> !dout);

   // R5: the enable latch moves only on an enable or disable command
   p_latch_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wen) |-> $past(cmd_vld && (cmd == CMD_OPEN || cmd == CMD_LOCK)));

   // R9: deselect forces the output low
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> !dout);

   // R11: deselect returns the slave to waiting for a start bit
   p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> idle);

endmodule

bind mw_eeprom_model mw_eeprom_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_s     (cs_s),
   .sk_rise  (sk_rise),
   .di_s     (di_s),
   .dout     (dout),
   .idle     (idle),
   .rd_start (rd_start),
   .cmd_vld  (cmd_vld),
   .cmd      (cmd),
   .wen      (wen)
);

// File: tb/tb_mw_eeprom_model.sv
module tb_mw_eeprom_model;

   localparam int HALF = 5;
   localparam int NW   = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0;
   logic sk = 1'b0;
   logic di = 1'b0;
   logic dout;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] model [NW];

   always #2 clk = ~clk;

   mw_eeprom_model dut (
      .clk   (clk),
      .rst_n (rst_n),
      .cs    (cs),
      .sk    (sk),
      .di    (di),
      .dout  (dout)
   );

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bit_out(input logic b);
      @(negedge clk) di = b;
      repeat (HALF) @(negedge clk);
      sk = 1'b1;
      repeat (HALF) @(negedge clk);
      sk = 1'b0;
   endtask

   task automatic sel;
      @(negedge clk) cs = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic desel;
      @(negedge clk) cs = 1'b0;
      di = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic head(input logic [1:0] op, input logic [5:0] a);
      bit_out(1'b1);
      for (int i = 1; i >= 0; i--) bit_out(op[i]);
      for (int i = 5; i >= 0; i--) bit_out(a[i]);
   endtask

   task automatic cmd(input logic [1:0] op, input logic [5:0] a, input bit with_data,
                      input logic [15:0] d);
      sel();
      head(op, a);
      if (with_data)
         for (int i = 15; i >= 0; i--) bit_out(d[i]);
      desel();
   endtask

   task automatic read_word(input logic [5:0] a, input string req, output logic [15:0] v);
      sel();
      head(2'b10, a);
      check("R2 leading zero", {15'd0, dout}, 16'd0);
      for (int i = 15; i >= 0; i--) begin
         bit_out(1'b0);
         v[i] = dout;
      end
      bit_out(1'b0);
      check({req, " low after read"}, {15'd0, dout}, 16'd0);
      desel();
   endtask

   task automatic sweep(input string req);
      logic [15:0] v;
      for (int a = 0; a < NW; a++) begin
         read_word(6'(a), req, v);
         check(req, v, model[a]);
      end
   endtask

   initial begin
      repeat (400000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] v;
      for (int a = 0; a < NW; a++) model[a] = 16'hFFFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R9 idle output", {15'd0, dout}, 16'd0);

      // R10: reset contents
      sweep("R10 reset value");

      // R8: write while latch clear
      cmd(2'b01, 6'd5, 1, 16'h1234);
      read_word(6'd5, "R8", v);
      check("R8 write locked", v, 16'hFFFF);

      // R5: enable with arbitrary low bits
      cmd(2'b00, 6'b11_0101, 0, '0);

      // R3: write every address
      for (int a = 0; a < NW; a++) begin
         model[a] = 16'(a * 16'h0101) ^ 16'hA5C3;
         cmd(2'b01, 6'(a), 1, model[a]);
      end
      sweep("R3 R2 write sweep");

      // R4: erase one word
      cmd(2'b11, 6'd7, 0, '0);
      model[7] = 16'hFFFF;
      read_word(6'd7, "R4", v);
      check("R4 erased word", v, 16'hFFFF);
      read_word(6'd8, "R4", v);
      check("R4 neighbour kept", v, model[8]);

      // R1: leading zeros then read
      sel();
      bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
      check("R9 low before start", {15'd0, dout}, 16'd0);
      head(2'b10, 6'd9);
      for (int i = 15; i >= 0; i--) begin
         bit_out(1'b0);
         v[i] = dout;
      end
      check("R1 leading zeros", v, model[9]);
      desel();

      // R1: clocks while deselected do nothing
      for (int i = 0; i < 25; i++) bit_out(1'b1);
      read_word(6'd9, "R1", v);
      check("R1 deselected clocks", v, model[9]);

      // R11: aborted write
      sel();
      head(2'b01, 6'd9);
      for (int i = 0; i < 8; i++) bit_out(1'b0);
      desel();
      read_word(6'd9, "R11", v);
      check("R11 aborted write", v, model[9]);

      // R5 R8: disable, then programming is blocked
      cmd(2'b00, 6'b00_1010, 0, '0);
      cmd(2'b11, 6'd3, 0, '0);
      read_word(6'd3, "R8", v);
      check("R8 erase locked", v, model[3]);
      cmd(2'b00, 6'b10_0000, 0, '0);
      read_word(6'd4, "R8", v);
      check("R8 wipe locked", v, model[4]);
      cmd(2'b00, 6'b01_1111, 1, 16'h0000);
      read_word(6'd6, "R8", v);
      check("R8 fill locked", v, model[6]);

      // R6: erase all
      cmd(2'b00, 6'b11_0000, 0, '0);
      cmd(2'b00, 6'b10_0110, 0, '0);
      for (int a = 0; a < NW; a++) model[a] = 16'hFFFF;
      sweep("R6 erase all");

      // R7: write all
      cmd(2'b00, 6'b01_1001, 1, 16'h5A3C);
      for (int a = 0; a < NW; a++) model[a] = 16'h5A3C;
      sweep("R7 write all");

      check("R9 idle at end", {15'd0, dout}, 16'd0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule